// File: doc/BRIEF.md
# Maskable Interrupt Status Controller

This block collects seven single-cycle event pulses from a timing peripheral and turns them into one level interrupt request for a host bus. Each pulse sets its own sticky status bit. A status bit latches whether or not its source is masked. A per-source mask register and a global run input decide whether the set bits reach the request line.

The host sees two 32-bit registers through a plain register port. It reads and writes the source mask at offset 0x18. It reads the latched status at offset 0x1C, and clears status bits by writing ones to them. Bits 31..7 of both registers are reserved. Because a status bit stays set until the host clears it, a later pulse from the same source produces no new request edge. The host must clear the bit first.

Top module: `evt_irq_ctrl`

## Requirements
- R1: A synchronous active-high reset clears the mask, the status, `irq_req` and `reg_rdata` to zero.
- R2: A pulse on `evt_pulse[i]` sets status bit i at the next clock edge, whatever mask bit i holds. Bit i maps to a source as follows: 0 event input, 1 periodic output, 2 time-coincidence strobe, 3 one-per-second output, 4 data packet ready, 5 edge on event input 2, 6 edge on event input 3.
- R3: A set status bit stays set until the host clears it. Further pulses on a set bit change nothing.
- R4: A write to offset 0x1C clears each status bit whose `reg_wdata` bit is 1, and leaves every bit whose data bit is 0 unchanged. Writing 0x7F clears all seven bits.
- R5: When a pulse and a host clear hit the same status bit in the same cycle, the bit ends up set.
- R6: A write to offset 0x18 loads mask bits 6..0 from `reg_wdata[6:0]`. A 1 enables a source and a 0 disables it.
- R7: After each clock edge, `irq_req` is 1 exactly when `irq_run` was 1 at that edge and at least one bit is set in both the new status and the new mask.
- R8: While `irq_run` is 0, `irq_req` stays 0, and status bits still latch their events.
- R9: A read strobe returns, at the next edge, the mask value (offset 0x18) or the status value (offset 0x1C) as it stood before that edge. Any other offset returns 0. Bits 31..7 always read 0. Writes to other offsets and to reserved bits have no effect. Without a strobe, `reg_rdata` holds its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_pulse | input | 7 | One-cycle event pulses, one per source |
| irq_run | input | 1 | Global interrupt start (1) or stop (0) |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 8 | Byte offset of the register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Registered read data |
| irq_req | output | 1 | Registered level interrupt request |

## Verification
The assertions assume that `reg_wr` and `reg_rd` are never both high in one cycle. They also assume that `evt_pulse` and the register port are stable across each rising edge. The bench drives every input on the falling edge and never raises both strobes together. A pulse may overlap a clear, and the directed phases force that overlap on purpose.

// File: rtl/irq_ctl_pkg.sv
package irq_ctl_pkg;
  localparam int unsigned SRC_COUNT  = 7;
  localparam int unsigned BUS_W      = 32;
  localparam int unsigned OFS_W      = 8;
  localparam logic [7:0]  OFS_MASK   = 8'h18;
  localparam logic [7:0]  OFS_STATUS = 8'h1C;

  typedef enum logic [1:0] {
    SEL_NONE   = 2'd0,
    SEL_MASK   = 2'd1,
    SEL_STATUS = 2'd2
  } reg_sel_e;
endpackage

// File: rtl/irq_mask_reg.sv
module irq_mask_reg #(
  parameter int unsigned N = 7
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         ld_en,
  input  logic [N-1:0] ld_bits,
  output logic [N-1:0] mask_q,
  output logic [N-1:0] mask_nx
);
  always_comb mask_nx = ld_en ? ld_bits : mask_q;

  always_ff @(posedge clk) begin
    if (rst) mask_q <= '0;
    else     mask_q <= mask_nx;
  end

  assert_load_R6: assert property (@(posedge clk) disable iff (rst)
    ld_en |=> (mask_q == $past(ld_bits)));
  assert_hold_R6: assert property (@(posedge clk) disable iff (rst)
    !ld_en |=> $stable(mask_q));
endmodule

// File: rtl/irq_status_reg.sv
module irq_status_reg #(
  parameter int unsigned N = 7
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] evt,
  input  logic [N-1:0] clr_bits,
  output logic [N-1:0] stat_q,
  output logic [N-1:0] stat_nx
);
  for (genvar g = 0; g < N; g++) begin : g_cell
    always_comb stat_nx[g] = evt[g] | (stat_q[g] & ~clr_bits[g]);

    always_ff @(posedge clk) begin
      if (rst) stat_q[g] <= 1'b0;
      else     stat_q[g] <= stat_nx[g];
    end

    assert_set_R2: assert property (@(posedge clk) disable iff (rst)
      evt[g] |=> stat_q[g]);
    assert_sticky_R3: assert property (@(posedge clk) disable iff (rst)
      (stat_q[g] && !clr_bits[g]) |=> stat_q[g]);
    assert_clear_R4: assert property (@(posedge clk) disable iff (rst)
      (clr_bits[g] && !evt[g]) |=> !stat_q[g]);
    assert_setwins_R5: assert property (@(posedge clk) disable iff (rst)
      (clr_bits[g] && evt[g]) |=> stat_q[g]);
  end
endmodule

// File: rtl/irq_req_gen.sv
module irq_req_gen #(
  parameter int unsigned N = 7
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         run,
  input  logic [N-1:0] stat_nx,
  input  logic [N-1:0] mask_nx,
  output logic         req_q
);
  logic hit;
  always_comb hit = |(stat_nx & mask_nx);

  always_ff @(posedge clk) begin
    if (rst) req_q <= 1'b0;
    else     req_q <= run & hit;
  end

  assert_stop_R8: assert property (@(posedge clk) disable iff (rst)
    !run |=> !req_q);
  assert_raise_R7: assert property (@(posedge clk) disable iff (rst)
    (run && (stat_nx & mask_nx) != '0) |=> req_q);
endmodule

// File: rtl/evt_irq_ctrl.sv
module evt_irq_ctrl
  import irq_ctl_pkg::*;
#(
  parameter int unsigned NSRC   = SRC_COUNT,
  parameter int unsigned DW     = BUS_W,
  parameter int unsigned AW     = OFS_W,
  parameter logic [AW-1:0] MASK_AT = AW'(OFS_MASK),
  parameter logic [AW-1:0] STAT_AT = AW'(OFS_STATUS)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NSRC-1:0] evt_pulse,
  input  logic            irq_run,
  input  logic            reg_wr,
  input  logic            reg_rd,
  input  logic [AW-1:0]   reg_addr,
  input  logic [DW-1:0]   reg_wdata,
  output logic [DW-1:0]   reg_rdata,
  output logic            irq_req
);
  localparam int unsigned PAD_W = DW - NSRC;

  reg_sel_e        sel;
  logic [NSRC-1:0] mask_q, mask_nx, stat_q, stat_nx, clr_bits;
  logic            mask_ld;

  always_comb begin
    if (reg_addr == MASK_AT)      sel = SEL_MASK;
    else if (reg_addr == STAT_AT) sel = SEL_STATUS;
    else                          sel = SEL_NONE;
  end

  always_comb mask_ld  = reg_wr && (sel == SEL_MASK);
  always_comb clr_bits = (reg_wr && (sel == SEL_STATUS)) ? reg_wdata[NSRC-1:0] : '0;

  irq_mask_reg #(.N(NSRC)) u_mask (
    .clk(clk), .rst(rst), .ld_en(mask_ld), .ld_bits(reg_wdata[NSRC-1:0]),
    .mask_q(mask_q), .mask_nx(mask_nx));

  irq_status_reg #(.N(NSRC)) u_stat (
    .clk(clk), .rst(rst), .evt(evt_pulse), .clr_bits(clr_bits),
    .stat_q(stat_q), .stat_nx(stat_nx));

  irq_req_gen #(.N(NSRC)) u_req (
    .clk(clk), .rst(rst), .run(irq_run), .stat_nx(stat_nx),
    .mask_nx(mask_nx), .req_q(irq_req));

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata <= '0;
    end else if (reg_rd) begin
      unique case (sel)
        SEL_MASK:   reg_rdata <= {{PAD_W{1'b0}}, mask_q};
        SEL_STATUS: reg_rdata <= {{PAD_W{1'b0}}, stat_q};
        default:    reg_rdata <= '0;
      endcase
    end
  end

  assert_rdmask_R9: assert property (@(posedge clk) disable iff (rst)
    (reg_rd && reg_addr == MASK_AT) |=> (reg_rdata[NSRC-1:0] == $past(mask_q)));
  assert_rdstat_R9: assert property (@(posedge clk) disable iff (rst)
    (reg_rd && reg_addr == STAT_AT) |=> (reg_rdata[NSRC-1:0] == $past(stat_q)));
  assert_rdhold_R9: assert property (@(posedge clk) disable iff (rst)
    !reg_rd |=> $stable(reg_rdata));
  assert_strobes_R9: assert property (@(posedge clk) disable iff (rst)
    !(reg_rd && reg_wr));
endmodule

// File: tb/test_evt_irq_ctrl.sv
module test_evt_irq_ctrl;
  localparam time CLK_PERIOD = 10ns;
  localparam int  WATCHDOG   = 20000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [6:0]  evt_pulse = '0;
  logic        irq_run = 1'b0;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        irq_req;

  int errors = 0, checks = 0, cycles = 0;
  bit done = 0;

  logic [6:0]  m_mask = '0, m_stat = '0;
  logic [31:0] m_rdata = '0;
  logic        m_irq = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  evt_irq_ctrl i_evt_irq_ctrl (
    .clk(clk), .rst(rst), .evt_pulse(evt_pulse), .irq_run(irq_run),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_req(irq_req));

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp, input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic step(input string tag, input logic [6:0] e, input logic w, input logic r,
                      input logic [7:0] a, input logic [31:0] d);
    logic [6:0] clr;
    evt_pulse = e; reg_wr = w; reg_rd = r; reg_addr = a; reg_wdata = d;
    @(posedge clk);
    if (r) begin
      if (a == 8'h18)      m_rdata = {25'd0, m_mask};
      else if (a == 8'h1C) m_rdata = {25'd0, m_stat};
      else                 m_rdata = '0;
    end
    if (w && a == 8'h18) m_mask = d[6:0];
    clr = (w && a == 8'h1C) ? d[6:0] : 7'd0;
    m_stat = (m_stat & ~clr) | e;
    m_irq  = irq_run && ((m_stat & m_mask) != 0);
    @(negedge clk);
    check(tag, {31'd0, irq_req}, {31'd0, m_irq}, "irq_req");
    check(tag, reg_rdata, m_rdata, "reg_rdata");
    evt_pulse = '0; reg_wr = 0; reg_rd = 0;
  endtask

  task automatic idle(input string tag);
    step(tag, 7'd0, 0, 0, 8'h00, 32'd0);
  endtask

  task automatic rd(input string tag, input logic [7:0] a);
    step(tag, 7'd0, 0, 1, a, 32'd0);
  endtask

  task automatic wr(input string tag, input logic [7:0] a, input logic [31:0] d);
    step(tag, 7'd0, 1, 0, a, d);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG) begin
      checks++; errors++;
      $display("FAIL watchdog expired: actual=%0d expected<=%0d cycles", cycles, WATCHDOG);
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    // R1 reset state
    check("R1", {31'd0, irq_req}, 32'd0, "irq_req after reset");
    check("R1", reg_rdata, 32'd0, "reg_rdata after reset");
    rd("R1", 8'h18);
    rd("R1", 8'h1C);

    // R2 / R8: events latch while masked and stopped
    for (int i = 0; i < 7; i++) step("R2", 7'(1 << i), 0, 0, 8'h00, 32'd0);
    rd("R2", 8'h1C);
    wr("R8", 8'h18, 32'h7F);
    idle("R8");
    rd("R8", 8'h1C);

    // R7: start interrupts
    irq_run = 1;
    idle("R7");
    wr("R4", 8'h1C, 32'h7F);
    rd("R4", 8'h1C);

    // R3: repeated pulse on a set bit
    step("R3", 7'h04, 0, 0, 8'h00, 32'd0);
    step("R3", 7'h04, 0, 0, 8'h00, 32'd0);
    idle("R3");
    rd("R3", 8'h1C);

    // R4: zeros leave bits, ones clear selected bits
    step("R4", 7'h13, 0, 0, 8'h00, 32'd0);
    wr("R4", 8'h1C, 32'h00);
    rd("R4", 8'h1C);
    wr("R4", 8'h1C, 32'h02);
    rd("R4", 8'h1C);
    wr("R4", 8'h1C, 32'h7F);
    rd("R4", 8'h1C);

    // R5: pulse and clear together
    step("R5", 7'h08, 0, 0, 8'h00, 32'd0);
    step("R5", 7'h08, 1, 0, 8'h1C, 32'h7F);
    rd("R5", 8'h1C);
    wr("R5", 8'h1C, 32'h08);

    // R6: mask load and per-source gating
    wr("R6", 8'h18, 32'h21);
    rd("R6", 8'h18);
    step("R6", 7'h02, 0, 0, 8'h00, 32'd0);
    step("R6", 7'h20, 0, 0, 8'h00, 32'd0);
    wr("R6", 8'h18, 32'h00);
    wr("R6", 8'h18, 32'h20);

    // R8: stop while pending
    irq_run = 0;
    idle("R8");
    step("R8", 7'h40, 0, 0, 8'h00, 32'd0);
    rd("R8", 8'h1C);
    irq_run = 1;
    idle("R7");

    // R9: reserved bits, other offsets
    wr("R9", 8'h18, 32'hFFFF_FF80);
    rd("R9", 8'h18);
    wr("R9", 8'h18, 32'hFFFF_FFFF);
    rd("R9", 8'h18);
    wr("R9", 8'h1C, 32'hFFFF_FF80);
    rd("R9", 8'h1C);
    wr("R9", 8'h20, 32'hFFFF_FFFF);
    rd("R9", 8'h20);
    rd("R9", 8'h18);
    idle("R9");

    // R7: mixed random traffic
    for (int n = 0; n < 400; n++) begin
      logic [6:0] e;
      logic [1:0] op;
      logic [7:0] a;
      e  = 7'($urandom) & 7'($urandom) & 7'($urandom);
      op = 2'($urandom);
      a  = ($urandom % 3 == 0) ? 8'h18 : (($urandom % 4 == 0) ? 8'h24 : 8'h1C);
      if (n % 37 == 0) irq_run = ~irq_run;
      step("R7", e, op == 2'd1, op == 2'd2, a, $urandom);
    end
    finish_run();
  end
endmodule